// File: doc/BRIEF.md
# Transmit Descriptor Ring Queue Manager

This block tracks a circular queue of transmit descriptors that software fills and hardware drains. Software owns the produce index and writes it to hand descriptors over; the block owns the consume index and moves it forward each time the transmitter accepts a frame. A size register holds the ring size minus one, and both indices wrap to zero after the entry that register names.

Each ring entry has two 32-bit words held in a small internal descriptor memory: a packet pointer and a control word. The control word carries the frame length minus one and a last-fragment flag. While transmission is enabled and the ring holds work, the entry at the consume index is offered on a valid/ready request port, with the length given as a true byte count. When the frame is accepted, a one-word completion status is written for that entry and the consume index advances. Software reads the status words back through a read port. DMA bus mastering, serialisation and CRC generation are left to other blocks.

Top module: `txq_ring_mgr`

## Requirements
- R1: After reset the produce and consume indices are 0, the ring size is NUM_RST+1 (4 entries by default), no request is offered, tx_active is low and every status word reads 0.
- R2: A size-register write holds the ring size minus one. It is accepted only while tx_en is low and the value is non-zero; an accepted write sets both indices to 0 and clears all status words. Indices wrap to 0 after the entry equal to the stored value.
- R3: A produce-index write is ignored when its value exceeds the stored size-minus-one or when the ring is full; otherwise the produce index takes the written value.
- R4: ring_full is high exactly when (produce+1) modulo the ring size equals consume; the ring is empty when the two indices are equal.
- R5: req_valid is high only while tx_en is high and the ring is not empty. It offers the entry at the consume index: req_ptr is its pointer word, req_len is control bits 10:0 plus one, req_last is control bit 30. With req_valid low, req_ready has no effect.
- R6: On a cycle with req_valid and req_ready both high, the status word of the consumed entry becomes bit 31 = 1, bit 30 = req_err, bits 10:0 = the control word's length-minus-one field, other bits 0, and the consume index advances by one with wrap.
- R7: tx_active is high exactly when the produce and consume indices differ.
- R8: When a produce write and a frame acceptance fall in the same cycle, the full test uses the indices from before that cycle: a write into a full ring is dropped even though an entry is freed, and otherwise both updates take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmit enable |
| desc_we | input | 1 | Descriptor memory write strobe |
| desc_sel | input | 1 | 0 selects the pointer word, 1 the control word |
| desc_idx | input | IDX_W | Descriptor entry to write |
| desc_wdata | input | 32 | Descriptor word data |
| num_we | input | 1 | Size register write strobe |
| num_wdata | input | IDX_W | Ring size minus one |
| prod_we | input | 1 | Produce index write strobe |
| prod_wdata | input | IDX_W | New produce index |
| prod_idx | output | IDX_W | Current produce index |
| cons_idx | output | IDX_W | Current consume index |
| ring_full | output | 1 | Ring full flag |
| tx_active | output | 1 | Descriptors pending |
| req_valid | output | 1 | Frame request valid |
| req_ready | input | 1 | Transmitter accepts the frame |
| req_err | input | 1 | Error flag recorded with the accepted frame |
| req_ptr | output | 32 | Packet pointer of the offered entry |
| req_len | output | LEN_W+1 | Frame length in bytes |
| req_last | output | 1 | Last-fragment flag |
| stat_idx | input | IDX_W | Status entry to read |
| stat_rdata | output | 32 | Status word of that entry |

## Verification
The two functions that can coincide are a software produce-index write and the transmitter's acceptance of a frame. The bench sweeps every ring size from two to eight entries, fills each ring completely, and then on the first acceptance also writes the produce index: the ring was full before the edge, so the write must be dropped while the consume index still moves. On the next acceptance it repeats the write with the ring no longer full, and both indices must then move; the index values after the edge and the status words left behind show which outcome occurred.

// File: rtl/txq_ring_mgr.sv
module txq_ring_mgr #(
  parameter int IDX_W   = 3,
  parameter int LEN_W   = 11,
  parameter int NUM_RST = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             desc_we,
  input  logic             desc_sel,
  input  logic [IDX_W-1:0] desc_idx,
  input  logic [31:0]      desc_wdata,
  input  logic             num_we,
  input  logic [IDX_W-1:0] num_wdata,
  input  logic             prod_we,
  input  logic [IDX_W-1:0] prod_wdata,
  output logic [IDX_W-1:0] prod_idx,
  output logic [IDX_W-1:0] cons_idx,
  output logic             ring_full,
  output logic             tx_active,
  output logic             req_valid,
  input  logic             req_ready,
  input  logic             req_err,
  output logic [31:0]      req_ptr,
  output logic [LEN_W:0]   req_len,
  output logic             req_last,
  input  logic [IDX_W-1:0] stat_idx,
  output logic [31:0]      stat_rdata
);
  localparam int DEPTH    = 1 << IDX_W;
  localparam int LAST_BIT = 30;
  localparam int DONE_BIT = 31;
  localparam int ERR_BIT  = 30;

  logic [IDX_W-1:0] num_q, prod_q, cons_q;
  logic [31:0] ptr_mem  [DEPTH];
  logic [31:0] ctl_mem  [DEPTH];
  logic [31:0] stat_mem [DEPTH];

  function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] i, input logic [IDX_W-1:0] lim);
    return (i == lim) ? '0 : IDX_W'(i + 1'b1);
  endfunction

  logic empty, num_acc, prod_acc, fire;
  logic [31:0] cur_ctl, done_word;

  assign empty     = (prod_q == cons_q);
  assign ring_full = (step(prod_q, num_q) == cons_q);
  assign tx_active = !empty;
  assign num_acc   = num_we && !tx_en && (num_wdata != '0);
  assign prod_acc  = prod_we && !ring_full && (prod_wdata <= num_q);
  assign req_valid = tx_en && !empty;
  assign fire      = req_valid && req_ready;

  assign cur_ctl  = ctl_mem[cons_q];
  assign req_ptr  = ptr_mem[cons_q];
  assign req_len  = {1'b0, cur_ctl[LEN_W-1:0]} + 1'b1;
  assign req_last = cur_ctl[LAST_BIT];

  always_comb begin
    done_word = '0;
    done_word[LEN_W-1:0] = cur_ctl[LEN_W-1:0];
    done_word[ERR_BIT]   = req_err;
    done_word[DONE_BIT]  = 1'b1;
  end

  assign prod_idx   = prod_q;
  assign cons_idx   = cons_q;
  assign stat_rdata = stat_mem[stat_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      num_q  <= IDX_W'(NUM_RST);
      prod_q <= '0;
      cons_q <= '0;
    end else if (num_acc) begin
      num_q  <= num_wdata;
      prod_q <= '0;
      cons_q <= '0;
    end else begin
      if (prod_acc) prod_q <= prod_wdata;
      if (fire)     cons_q <= step(cons_q, num_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        ptr_mem[i]  <= '0;
        ctl_mem[i]  <= '0;
        stat_mem[i] <= '0;
      end
    end else begin
      if (desc_we && !desc_sel) ptr_mem[desc_idx] <= desc_wdata;
      if (desc_we &&  desc_sel) ctl_mem[desc_idx] <= desc_wdata;
      if (num_acc) begin
        for (int i = 0; i < DEPTH; i++) stat_mem[i] <= '0;
      end else if (fire) begin
        stat_mem[cons_q] <= done_word;
      end
    end
  end

  // R2: both indices stay inside the configured ring
  p_idx_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (prod_q <= num_q) && (cons_q <= num_q));

  // R3 / R8: a write into a full ring leaves the produce index alone
  p_full_write_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_full && prod_we && !num_acc) |=> (prod_q == $past(prod_q)));

  // R6: an accepted frame moves the consume index one step with wrap
  p_cons_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=>
      (cons_q == (($past(cons_q) == num_q) ? '0 : IDX_W'($past(cons_q) + 1'b1))));

  // R5: without an accepted frame the consume index holds
  p_cons_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!(req_valid && req_ready) && !num_acc) |=> $stable(cons_q));

  // R5: an offered request is never withdrawn until taken or disabled
  p_req_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !num_acc && !prod_we) |=> (req_valid || !tx_en));
endmodule

// File: tb/txq_ring_mgr_tb.sv
module txq_ring_mgr_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 3;
  localparam int LEN_W = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b0, desc_we = 1'b0, desc_sel = 1'b0;
  logic [IDX_W-1:0] desc_idx = '0, num_wdata = '0, prod_wdata = '0, stat_idx = '0;
  logic [31:0] desc_wdata = '0;
  logic num_we = 1'b0, prod_we = 1'b0, req_ready = 1'b0, req_err = 1'b0;
  logic [IDX_W-1:0] prod_idx, cons_idx;
  logic ring_full, tx_active, req_valid, req_last;
  logic [31:0] req_ptr, stat_rdata;
  logic [LEN_W:0] req_len;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txq_ring_mgr #(.IDX_W(IDX_W), .LEN_W(LEN_W), .NUM_RST(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en),
    .desc_we(desc_we), .desc_sel(desc_sel), .desc_idx(desc_idx), .desc_wdata(desc_wdata),
    .num_we(num_we), .num_wdata(num_wdata),
    .prod_we(prod_we), .prod_wdata(prod_wdata),
    .prod_idx(prod_idx), .cons_idx(cons_idx), .ring_full(ring_full), .tx_active(tx_active),
    .req_valid(req_valid), .req_ready(req_ready), .req_err(req_err),
    .req_ptr(req_ptr), .req_len(req_len), .req_last(req_last),
    .stat_idx(stat_idx), .stat_rdata(stat_rdata));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr_num(int v);
    num_we = 1'b1; num_wdata = IDX_W'(v);
    tick();
    num_we = 1'b0;
  endtask

  task automatic wr_prod(int v);
    prod_we = 1'b1; prod_wdata = IDX_W'(v);
    tick();
    prod_we = 1'b0;
  endtask

  task automatic wr_desc(int i, bit sel, logic [31:0] d);
    desc_we = 1'b1; desc_sel = sel; desc_idx = IDX_W'(i); desc_wdata = d;
    tick();
    desc_we = 1'b0;
  endtask

  function automatic int nx(int i, int s);
    return (i + 1) % s;
  endfunction

  function automatic logic [31:0] ptr_of(int i, int s);
    return 32'h1000_0000 + 32'(i * 64 + s);
  endfunction

  function automatic logic [31:0] ctl_of(int i, int s);
    logic [31:0] c;
    c = '0;
    c[10:0] = 11'((i * 37 + s * 5 + 60) % 2048);
    c[30] = i[0];
    c[20] = 1'b1;
    return c;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] exp_stat [8];
    int mp, mc, k;
    bit wr, mfull, err;
    logic [31:0] c;

    #1;
    tick(); tick();
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1 prod", 32'(prod_idx), 0);
    check("R1 cons", 32'(cons_idx), 0);
    check("R1 req_valid", 32'(req_valid), 0);
    check("R1 tx_active", 32'(tx_active), 0);
    for (int i = 0; i < 8; i++) begin
      stat_idx = IDX_W'(i); #1;
      check("R1 status", stat_rdata, 0);
    end
    // R1: default size is four entries
    wr_prod(3);
    check("R1 default size full", 32'(ring_full), 1);
    check("R7 active", 32'(tx_active), 1);
    // R2: zero size value ignored, indices untouched
    wr_num(0);
    check("R2 zero size ignored", 32'(prod_idx), 3);

    for (int s = 2; s <= 8; s++) begin
      tx_en = 1'b0;
      wr_num(s - 1);
      check("R2 prod cleared", 32'(prod_idx), 0);
      check("R2 cons cleared", 32'(cons_idx), 0);
      check("R4 empty not full", 32'(ring_full), 0);
      for (int i = 0; i < s; i++) begin
        wr_desc(i, 1'b0, ptr_of(i, s));
        wr_desc(i, 1'b1, ctl_of(i, s));
        exp_stat[i] = '0;
      end
      stat_idx = '0; #1;
      check("R2 status cleared", stat_rdata, 0);
      if (s < 8) begin
        wr_prod(s);
        check("R3 out of range ignored", 32'(prod_idx), 0);
      end
      for (int v = 1; v < s - 1; v++) begin
        wr_prod(v);
        check("R4 not full", 32'(ring_full), 0);
        check("R7 active", 32'(tx_active), 1);
      end
      wr_prod(s - 1);
      check("R3 in range taken", 32'(prod_idx), 32'(s - 1));
      check("R4 full", 32'(ring_full), 1);
      wr_prod(0);
      check("R3 full write ignored", 32'(prod_idx), 32'(s - 1));
      // R5: disabled transmitter offers nothing and ignores ready
      check("R5 disabled no request", 32'(req_valid), 0);
      req_ready = 1'b1; tick(); req_ready = 1'b0;
      check("R5 ready ignored", 32'(cons_idx), 0);

      tx_en = 1'b1; #1;
      mp = s - 1; mc = 0; k = 0;
      while (mp != mc && k < 20) begin
        c = ctl_of(mc, s);
        check("R5 valid", 32'(req_valid), 1);
        check("R5 ptr", req_ptr, ptr_of(mc, s));
        check("R5 len", 32'(req_len), 32'(c[10:0]) + 1);
        check("R5 last", 32'(req_last), 32'(c[30]));
        wr = (k == 0) || (k == 1 && s > 2);
        err = mc[1];
        mfull = (nx(mp, s) == mc);
        req_ready = 1'b1; req_err = err;
        prod_we = wr; prod_wdata = IDX_W'(nx(mp, s));
        if (wr && !mfull) mp = nx(mp, s);
        exp_stat[mc] = {1'b1, err, 19'b0, c[10:0]};
        mc = nx(mc, s);
        tick();
        req_ready = 1'b0; prod_we = 1'b0; req_err = 1'b0;
        check("R8 prod after same-cycle", 32'(prod_idx), 32'(mp));
        check("R6 cons advance", 32'(cons_idx), 32'(mc));
        k++;
      end
      check("R5 empty no request", 32'(req_valid), 0);
      check("R7 idle", 32'(tx_active), 0);
      for (int i = 0; i < s; i++) begin
        stat_idx = IDX_W'(i); #1;
        check("R6 status word", stat_rdata, exp_stat[i]);
      end
      if (s > 2) begin
        wr_num(1);
        tx_en = 1'b0;
        wr_prod(s - 1);
        check("R2 size write ignored while enabled", 32'(ring_full), 1);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule